// File: doc/BRIEF.md
# Memory-Mapped SPI Master Controller

This peripheral lets software exchange 8-bit words with an SPI target over a 32-bit register port. Software sets a clock divider, turns on the serial clock, loads the same byte count into a transmit counter and a receive counter, and fills a 16-entry transmit FIFO. It then sets the run and programmed-I/O bits to start. The shift engine sends each byte least-significant bit first in mode 0, and puts each received byte into a 16-entry receive FIFO. Software drains that FIFO through a read port. Chip select is driven outside the block.

Three sticky status flags record received data, a drained transmit FIFO and transfer completion. Software clears a flag by writing a one to its bit. Each flag has an enable bit in the control register, and the single level interrupt is the OR of every flag whose enable is set. Clearing the programmed-I/O bit while run is still set stops the engine once the current byte ends, and empties both FIFOs.

Top module: `spiHost`

## Requirements
- R1: After reset the divisor reads 2 and every other register reads 0. SCK and the interrupt are low.
- R2: The engine shifts only while the clock-gate register (offset 0x00) holds 0xD. With any other value no byte starts, SCK stays low and an active byte freezes.
- R3: Writes to the divisor (offset 0x30) are clamped into 2..2047. One SCK period equals the divisor in input clocks: SCK is low for floor(N/2) clocks and high for the rest.
- R4: The control register (offset 0x04) stores these bits: bit 5 programmed-I/O enable, bit 7 receive-flag enable, bit 8 transmit-empty-flag enable, bit 18 run and bit 21 done-flag enable. All other bits read 0.
- R5: Bytes are shifted LSB first in mode 0. MOSI changes only while SCK is low or on its falling edge, and MISO is sampled on the rising edge of SCK.
- R6: A write to offset 0x10 pushes bits [7:0] into the 16-entry transmit FIFO. A write to a full FIFO is ignored.
- R7: A read at offset 0x20 returns the oldest received byte in bits [7:0] and pops it. Reading an empty FIFO returns 0.
- R8: The level register (offset 0x10C) reports transmit occupancy in bits [15:8] and receive occupancy in bits [31:24]. Its other bits read 0.
- R9: The transmit count (offset 0x4C) drops by one each time a byte starts, and the receive count (offset 0x34) drops by one each time a byte is received. A byte starts only when the transmit count is nonzero, the transmit FIFO has data and the receive FIFO has room. Otherwise SCK stays low.
- R10: The status register is at offset 0x08. Bit 0 is set when a byte arrives. Bit 1 is set when a pop empties the transmit FIFO. Bit 22 is set when the last byte arrives with both counts reaching zero. Writing 1 clears a bit, and a set in the same cycle takes priority over the clear.
- R11: The interrupt is high exactly when some status bit and its enable are both set.
- R12: If run is set and programmed-I/O is clear, no new byte starts. The active byte completes, and then both FIFOs are emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (a read at 0x20 pops the receive FIFO) |
| busAddr | input | 12 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Level interrupt |

## Verification
The bench drives a one-byte transfer at several divisors, including odd ones. A wrong low/high split or an off-by-one half counter shows up as a measured SCK period that differs from the programmed value, and a reversed shift direction returns mirrored bytes on both wires. The bench also starts a transfer with the clock gated off, and another with fewer bytes queued than counted. An engine that ignores the gate, or that starts on an empty FIFO, produces extra SCK edges and counts that drop too early. Pushing a seventeenth byte exposes a FIFO whose level wraps to zero. Withdrawing programmed-I/O in the middle of a byte catches two faults: an engine that aborts the byte, and one that keeps stale data in the FIFOs.

// File: rtl/spiHostPkg.sv
package spiHostPkg;
  localparam int ADDR_W  = 12;
  localparam int DIV_W   = 11;
  localparam int DIV_MIN = 2;
  localparam int DIV_MAX = 2047;
  localparam logic [3:0] GATE_ON = 4'hD;

  localparam logic [ADDR_W-1:0] OFS_GATE   = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_FLAGS  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_TXPORT = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_RXPORT = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_DIV    = 12'h030;
  localparam logic [ADDR_W-1:0] OFS_RXCNT  = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_TXCNT  = 12'h04C;
  localparam logic [ADDR_W-1:0] OFS_LEVELS = 12'h10C;

  localparam int CB_PIO = 5;
  localparam int CB_IE_RX = 7;
  localparam int CB_IE_TX = 8;
  localparam int CB_RUN = 18;
  localparam int CB_IE_DONE = 21;
  localparam int FB_RX = 0;
  localparam int FB_TX = 1;
  localparam int FB_DONE = 22;

  typedef struct packed {
    logic       txPop;
    logic       rxPush;
    logic [7:0] rxByte;
    logic       flush;
  } ctlStrobe_t;

  typedef struct packed {
    logic             go;
    logic             stop;
    logic             clkOn;
    logic [DIV_W-1:0] div;
    logic [7:0]       txHead;
    logic             txEmpty;
    logic             rxFull;
    logic             txCntZero;
  } dpState_t;
endpackage

// File: rtl/spiFifo.sv
module spiFifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic doPush, doPop;

  assign empty  = (level == '0);
  assign full   = (level == LVL_W'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && !empty;

  function automatic logic [PTR_W-1:0] nextPtr(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      level <= '0;
    end else if (flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      level <= level + LVL_W'(doPush) - LVL_W'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= pushData;
  end

  assign headData = mem[rdPtr];

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH)); // R6
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    full && push && !pop && !flush |=> full); // R6
endmodule

// File: rtl/spiDatapath.sv
module spiDatapath import spiHostPkg::*; #(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W = 16,
  localparam int LVL_W = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  ctlStrobe_t        ctl,
  output dpState_t          dp,
  output logic              irq
);
  logic [3:0] gateReg;
  logic cfgPio, cfgIeRx, cfgIeTx, cfgRun, cfgIeDone;
  logic flRx, flTx, flDone;
  logic [DIV_W-1:0] divReg;
  logic [CNT_W-1:0] txCnt, rxCnt;
  logic [7:0] txHead, rxHead;
  logic [LVL_W-1:0] txLvl, rxLvl;
  logic txFull, txEmpty, rxFull, rxEmpty;
  logic wrGate, wrCtrl, wrFlags, wrTx, wrDiv, wrRxCnt, wrTxCnt, rdRx;
  logic txPushOk, setRx, setTx, setDone;

  always_comb begin
    wrGate  = busWrEn && busAddr == OFS_GATE;
    wrCtrl  = busWrEn && busAddr == OFS_CTRL;
    wrFlags = busWrEn && busAddr == OFS_FLAGS;
    wrTx    = busWrEn && busAddr == OFS_TXPORT;
    wrDiv   = busWrEn && busAddr == OFS_DIV;
    wrRxCnt = busWrEn && busAddr == OFS_RXCNT;
    wrTxCnt = busWrEn && busAddr == OFS_TXCNT;
    rdRx    = busRdEn && busAddr == OFS_RXPORT;
  end

  assign txPushOk = wrTx && !txFull;
  assign setRx    = ctl.rxPush;
  assign setTx    = ctl.txPop && txLvl == LVL_W'(1) && !txPushOk;
  assign setDone  = ctl.rxPush && rxCnt == CNT_W'(1) && txCnt == '0;

  function automatic logic [DIV_W-1:0] clampDiv(logic [31:0] v);
    if (v < 32'(DIV_MIN)) return DIV_W'(DIV_MIN);
    else if (v > 32'(DIV_MAX)) return DIV_W'(DIV_MAX);
    else return v[DIV_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateReg <= '0;
      {cfgPio, cfgIeRx, cfgIeTx, cfgRun, cfgIeDone} <= '0;
      {flRx, flTx, flDone} <= '0;
      divReg <= DIV_W'(DIV_MIN);
      txCnt <= '0;
      rxCnt <= '0;
    end else begin
      if (wrGate) gateReg <= busWdata[3:0];
      if (wrCtrl) begin
        cfgPio    <= busWdata[CB_PIO];
        cfgIeRx   <= busWdata[CB_IE_RX];
        cfgIeTx   <= busWdata[CB_IE_TX];
        cfgRun    <= busWdata[CB_RUN];
        cfgIeDone <= busWdata[CB_IE_DONE];
      end
      if (wrDiv) divReg <= clampDiv(busWdata);
      flRx   <= setRx   | (flRx   & ~(wrFlags & busWdata[FB_RX]));
      flTx   <= setTx   | (flTx   & ~(wrFlags & busWdata[FB_TX]));
      flDone <= setDone | (flDone & ~(wrFlags & busWdata[FB_DONE]));
      if (wrTxCnt) txCnt <= busWdata[CNT_W-1:0];
      else if (ctl.txPop && txCnt != '0) txCnt <= txCnt - 1'b1;
      if (wrRxCnt) rxCnt <= busWdata[CNT_W-1:0];
      else if (ctl.rxPush && rxCnt != '0) rxCnt <= rxCnt - 1'b1;
    end
  end

  spiFifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) txFifo (
    .clk, .rstN, .flush(ctl.flush), .push(wrTx), .pushData(busWdata[7:0]),
    .pop(ctl.txPop), .headData(txHead), .level(txLvl), .full(txFull), .empty(txEmpty));

  spiFifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) rxFifo (
    .clk, .rstN, .flush(ctl.flush), .push(ctl.rxPush), .pushData(ctl.rxByte),
    .pop(rdRx), .headData(rxHead), .level(rxLvl), .full(rxFull), .empty(rxEmpty));

  always_comb begin
    busRdata = '0;
    case (busAddr)
      OFS_GATE:   busRdata[3:0] = gateReg;
      OFS_CTRL: begin
        busRdata[CB_PIO]     = cfgPio;
        busRdata[CB_IE_RX]   = cfgIeRx;
        busRdata[CB_IE_TX]   = cfgIeTx;
        busRdata[CB_RUN]     = cfgRun;
        busRdata[CB_IE_DONE] = cfgIeDone;
      end
      OFS_FLAGS: begin
        busRdata[FB_RX]   = flRx;
        busRdata[FB_TX]   = flTx;
        busRdata[FB_DONE] = flDone;
      end
      OFS_RXPORT: busRdata[7:0] = rxEmpty ? 8'h00 : rxHead;
      OFS_DIV:    busRdata = 32'(divReg);
      OFS_RXCNT:  busRdata = 32'(rxCnt);
      OFS_TXCNT:  busRdata = 32'(txCnt);
      OFS_LEVELS: busRdata = {8'(rxLvl), 8'h00, 8'(txLvl), 8'h00};
      default:    busRdata = '0;
    endcase
  end

  always_comb begin
    dp.go        = cfgRun && cfgPio;
    dp.stop      = cfgRun && !cfgPio;
    dp.clkOn     = (gateReg == GATE_ON);
    dp.div       = divReg;
    dp.txHead    = txHead;
    dp.txEmpty   = txEmpty;
    dp.rxFull    = rxFull;
    dp.txCntZero = (txCnt == '0);
  end

  assign irq = (flRx & cfgIeRx) | (flTx & cfgIeTx) | (flDone & cfgIeDone);

  AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    ctl.txPop |-> !txEmpty && txCnt != '0); // R9
  AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rxPush |-> !rxFull); // R9
  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    divReg >= DIV_W'(DIV_MIN) && divReg <= DIV_W'(DIV_MAX)); // R3
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (flRx | flTx | flDone)); // R11
  AST_NO_START_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRun && !cfgPio) |-> !ctl.txPop); // R12
  AST_NO_START_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (gateReg != GATE_ON) |-> !ctl.txPop); // R2
endmodule

// File: rtl/spiControl.sv
module spiControl import spiHostPkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  dpState_t   dp,
  output ctlStrobe_t ctl,
  output logic       sck,
  output logic       mosi,
  input  logic       miso
);
  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_t;
  phase_t phase;
  logic [DIV_W-1:0] halfCnt, loHalf, hiHalf;
  logic [2:0] bitIdx;
  logic [7:0] txSh, rxSh;
  logic start, lastBit;

  assign loHalf  = dp.div >> 1;
  assign hiHalf  = dp.div - loHalf;
  assign start   = phase == PH_IDLE && dp.clkOn && dp.go && !dp.txCntZero
                   && !dp.txEmpty && !dp.rxFull;
  assign lastBit = phase == PH_HIGH && dp.clkOn && halfCnt == '0 && bitIdx == 3'd7;

  always_comb begin
    ctl.txPop  = start;
    ctl.rxPush = lastBit;
    ctl.rxByte = rxSh;
    ctl.flush  = phase == PH_IDLE && dp.stop;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      halfCnt <= '0;
      bitIdx  <= '0;
      txSh    <= '0;
      rxSh    <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          txSh    <= dp.txHead;
          bitIdx  <= '0;
          halfCnt <= loHalf - 1'b1;
          phase   <= PH_LOW;
        end
        PH_LOW: if (dp.clkOn) begin
          if (halfCnt == '0) begin
            rxSh    <= {miso, rxSh[7:1]};
            halfCnt <= hiHalf - 1'b1;
            phase   <= PH_HIGH;
          end else halfCnt <= halfCnt - 1'b1;
        end
        PH_HIGH: if (dp.clkOn) begin
          if (halfCnt != '0) halfCnt <= halfCnt - 1'b1;
          else if (bitIdx == 3'd7) phase <= PH_IDLE;
          else begin
            bitIdx  <= bitIdx + 1'b1;
            txSh    <= txSh >> 1;
            halfCnt <= loHalf - 1'b1;
            phase   <= PH_LOW;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign sck  = (phase == PH_HIGH);
  assign mosi = txSh[0];

  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    sck |=> (sck ? $stable(mosi) : 1'b1)); // R5
  AST_GATED_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (!dp.clkOn && phase != PH_IDLE) |=> $stable(sck)); // R2
endmodule

// File: rtl/spiHost.sv
module spiHost import spiHostPkg::*; #(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [11:0] busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic        irq
);
  ctlStrobe_t ctl;
  dpState_t   dp;

  spiDatapath #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) uDatapath (
    .clk, .rstN, .busWrEn, .busRdEn, .busAddr, .busWdata, .busRdata,
    .ctl, .dp, .irq);

  spiControl uControl (
    .clk, .rstN, .dp, .ctl, .sck, .mosi, .miso);
endmodule

// File: tb/sim_spiHost.sv
module sim_spiHost;
  logic clk = 1'b0, rstN = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic sck, mosi, miso, irq;

  int errors = 0, checks = 0;
  int cyc = 0, lastRise = 0, period = 0, sckRises = 0;
  logic [31:0] slvTxFlat = '0, slvRx = '0;
  logic [4:0] slvPos = '0;

  localparam logic [31:0] RUN = 32'h0004_0000, PIO = 32'h0000_0020;
  localparam int NVEC = 4;
  localparam logic [31:0] VEC [NVEC] = '{32'h02A5_3C00, 32'h0301_8000,
                                          32'h06F0_0F00, 32'h095A_C300};

  always #2 clk = ~clk;

  spiHost u0 (.clk, .rstN, .busWrEn, .busRdEn, .busAddr, .busWdata, .busRdata,
              .sck, .mosi, .miso, .irq);

  assign miso = slvTxFlat[slvPos];
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge sck) begin
    slvRx[slvPos] <= mosi;
    slvPos   <= slvPos + 1'b1;
    sckRises <= sckRises + 1;
    period   <= cyc - lastRise;
    lastRise <= cyc;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busRdEn = 1'b1; #1 d = busRdata;
    @(negedge clk); busRdEn = 1'b0;
  endtask

  task automatic waitDone(output bit seen);
    logic [31:0] s;
    seen = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      rd(12'h008, s);
      seen = s[22];
    end
  endtask

  task automatic prime(input logic [31:0] dv, input int n);
    wr(12'h000, 0); wr(12'h030, dv); wr(12'h000, 32'hD);
    wr(12'h04C, n); wr(12'h034, n); wr(12'h008, 32'hFFFF_FFFF);
    slvPos = '0; sckRises = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    bit seen;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(12'h000, v); check("R1 gate", v, 0);
    rd(12'h004, v); check("R1 ctrl", v, 0);
    rd(12'h008, v); check("R1 flags", v, 0);
    rd(12'h030, v); check("R1 div", v, 2);
    rd(12'h10C, v); check("R1 levels", v, 0);
    rd(12'h04C, v); check("R1 txcnt", v, 0);
    check("R1 sck/irq", {30'd0, sck, irq}, 0);
    // R4 control bit layout
    wr(12'h004, 32'hFFFF_FFFF); rd(12'h004, v); check("R4 ctrl bits", v, 32'h0024_01A0);
    wr(12'h004, 0);
    // R3 clamp
    wr(12'h030, 0);    rd(12'h030, v); check("R3 clamp low", v, 2);
    wr(12'h030, 5000); rd(12'h030, v); check("R3 clamp high", v, 2047);
    wr(12'h030, 1);    rd(12'h030, v); check("R3 clamp one", v, 2);

    // vector table: divisor, byte out, byte in
    for (int k = 0; k < NVEC; k++) begin
      prime(32'(VEC[k][31:24]), 1);
      wr(12'h010, 32'(VEC[k][23:16]));
      slvTxFlat = {24'h0, VEC[k][15:8]};
      wr(12'h004, RUN | PIO);
      waitDone(seen);
      check("R10 done flag", 32'(seen), 1);
      check("R5 mosi byte", 32'(slvRx[7:0]), 32'(VEC[k][23:16]));
      rd(12'h020, v); check("R5 R7 miso byte", v, 32'(VEC[k][15:8]));
      check("R3 sck period", 32'(period), 32'(VEC[k][31:24]));
      wr(12'h004, RUN); wr(12'h004, 0);
    end

    // R8 R10 multi-byte
    prime(2, 3);
    wr(12'h010, 32'h11); wr(12'h010, 32'h22); wr(12'h010, 32'h33);
    rd(12'h10C, v); check("R8 tx level", v, 32'h0000_0300);
    slvTxFlat = 32'h00CC_BBAA;
    wr(12'h004, RUN | PIO);
    waitDone(seen);
    rd(12'h10C, v); check("R8 rx level", v, 32'h0300_0000);
    rd(12'h008, v); check("R10 flags", v, 32'h0040_0003);
    wr(12'h008, 32'h1); rd(12'h008, v); check("R10 w1c", v, 32'h0040_0002);
    rd(12'h020, v); check("R7 first", v, 32'hAA);
    rd(12'h020, v); check("R7 second", v, 32'hBB);
    rd(12'h020, v); check("R7 third", v, 32'hCC);
    check("R5 three bytes out", 32'(slvRx[23:0]), 32'h0033_2211);
    rd(12'h020, v); check("R7 empty reads zero", v, 0);
    // R11 interrupt
    wr(12'h004, 32'h100);    check("R11 tx source", 32'(irq), 1);
    wr(12'h004, 32'h80);     check("R11 rx cleared", 32'(irq), 0);
    wr(12'h004, 32'h200000); check("R11 done source", 32'(irq), 1);
    wr(12'h008, 32'hFFFF_FFFF); check("R11 after clear", 32'(irq), 0);
    wr(12'h004, 0);

    // R2 gated clock
    prime(2, 1);
    wr(12'h000, 0);
    wr(12'h010, 32'h5A);
    wr(12'h004, RUN | PIO);
    repeat (60) @(negedge clk);
    check("R2 no sck when gated", 32'(sckRises), 0);
    rd(12'h04C, v); check("R2 count held", v, 1);
    wr(12'h000, 32'hD);
    waitDone(seen);
    check("R2 runs after gate", 32'(sckRises), 8);
    wr(12'h004, RUN); wr(12'h004, 0);

    // R9 stall on empty tx
    prime(2, 2);
    wr(12'h010, 32'h0F);
    wr(12'h004, RUN | PIO);
    repeat (60) @(negedge clk);
    check("R9 one byte only", 32'(sckRises), 8);
    rd(12'h04C, v); check("R9 txcnt", v, 1);
    rd(12'h034, v); check("R9 rxcnt", v, 1);
    wr(12'h010, 32'hF0);
    waitDone(seen);
    check("R9 resumed", 32'(sckRises), 16);
    rd(12'h10C, v); check("R9 rx level", v, 32'h0200_0000);
    wr(12'h004, RUN); wr(12'h004, 0);

    // R6 overflow
    prime(2, 16);
    for (int i = 0; i < 17; i++) wr(12'h010, i);
    rd(12'h10C, v); check("R6 full level", v, 32'h0000_1000);
    wr(12'h004, RUN | PIO);
    waitDone(seen);
    rd(12'h10C, v); check("R6 sixteen moved", v, 32'h1000_0000);
    wr(12'h004, RUN); wr(12'h004, 0);

    // R12 stop mid-byte
    prime(4, 4);
    for (int i = 0; i < 4; i++) wr(12'h010, 32'h40 + i);
    wr(12'h004, RUN | PIO);
    for (int i = 0; i < 200 && sckRises == 0; i++) @(negedge clk);
    wr(12'h004, RUN);
    repeat (100) @(negedge clk);
    check("R12 byte finished", 32'(sckRises), 8);
    rd(12'h10C, v); check("R12 flushed", v, 0);
    rd(12'h04C, v); check("R12 txcnt", v, 3);
    wr(12'h004, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule